// File: doc/BRIEF.md
# One-Second Line Performance Report Generator

This block watches a T1 line's error indications and, once per second, turns what it saw into a small performance report frame. Single-cycle strobes flag CRC errors, severely errored framing, framing bit errors, line code violations and controlled slips. The block tallies these strobes between one-second ticks. When a tick arrives, it condenses the tally into a sixteen-bit status word. That word goes into a short history, and the block then emits one report as a byte stream.

Each report contains three header octets: an address octet that identifies the sender side, a second address octet, and a control octet. These are followed by the status words of the current second and the three seconds before it, and then a 16-bit frame check sequence. The stream uses valid/ready flow control with start-of-frame and end-of-frame markers. A downstream framer is expected to add flags and bit stuffing.

Top module: `perf_report_gen`

## Requirements
- R1: The first octet of every report is 0x38 when `carrier_i` is 0 and 0x3A when `carrier_i` is 1. `carrier_i` is sampled in the cycle the frame is loaded.
- R2: The second and third octets are 0x01 and 0x03. A report is exactly 13 octets long, `rep_sop_o` marks octet 0 and `rep_eop_o` marks octet 12. After reset no octet is offered.
- R3: A status word is sixteen bits, sent high octet first. Bits 15..10 hold the CRC-error range flags G6..G1, and at most one of them is set. The count of CRC error strobes in the second selects the flag: 0 sets none, 1 sets G1, 2–5 G2, 6–10 G3, 11–100 G4, 101–319 G5, and 320 or more G6.
- R4: Bit 7 (SE), bit 6 (FE), bit 5 (LV) and bit 4 (SL) are set when at least one severely errored framing, framing bit error, line code violation or slip strobe occurred in that second.
- R5: Bit 3 (LB) equals `loopback_i` in the tick cycle. Bits 2..0 are always 0.
- R6: Bits 9..8 carry a two-bit sequence count. It is 0 in the first report after reset and advances by one, modulo 4, per tick.
- R7: Octets 3..10 hold four status words: the current second's, then the three previous seconds' in order. Slots not yet filled since reset are zero.
- R8: Octets 11 and 12 are the low and high bytes of the complemented CRC-16 over octets 0..10. The CRC uses x^16+x^12+x^5+1, a preset of 0xFFFF, and least significant bit first processing, i.e. reflected polynomial 0x8408.
- R9: The tallies restart at each tick. A strobe in the tick cycle is counted in the new second.
- R10: The CRC error tally saturates at its maximum of 511 by default. While saturated it keeps reporting G6.
- R11: While `rep_valid_o` is high and `rep_ready_i` is low, the offered octet and markers stay unchanged.
- R12: A tick that arrives while a report is being sent starts one further report right after the current one ends. That further report carries the history as updated by that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick_i | input | 1 | One-second tick, one cycle wide |
| carrier_i | input | 1 | 1: report sent from carrier side, 0: customer side |
| loopback_i | input | 1 | Payload loopback active level |
| crc_err_i | input | 1 | CRC error strobe |
| sev_frm_i | input | 1 | Severely errored framing strobe |
| fbit_err_i | input | 1 | Framing bit error strobe |
| lcv_i | input | 1 | Line code violation strobe |
| slip_i | input | 1 | Slip strobe |
| rep_ready_i | input | 1 | Downstream accepts an octet |
| rep_valid_o | output | 1 | Octet offered |
| rep_data_o | output | 8 | Report octet |
| rep_sop_o | output | 1 | First octet of a report |
| rep_eop_o | output | 1 | Last octet of a report |

## Verification
The assertions take for granted that the tick and the event inputs are clean single-cycle strobes sampled on the clock. They also assume that at most one extra tick arrives while a report is in flight, since a second extra tick is merged into the pending request rather than queued. The stimulus drives every input at the falling edge. It sweeps the CRC error count across each range boundary, including a count above the saturation limit, and gives every second a different flag pattern. It places strobes inside the tick cycle and fires one extra tick a few cycles after a report starts. It also throttles `rep_ready_i` on alternate seconds to exercise the hold behaviour.

// File: rtl/perf_report_pkg.sv
package perf_report_pkg;

    localparam logic [7:0] ADDR_CUSTOMER = 8'h38;
    localparam logic [7:0] ADDR_CARRIER  = 8'h3A;
    localparam logic [7:0] ADDR_TEI      = 8'h01;
    localparam logic [7:0] CTRL_UI       = 8'h03;
    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam int          HDR_OCTETS   = 3;
    localparam int          FCS_OCTETS   = 2;

    // Per-second status word; sent high octet first.
    typedef struct packed {
        logic [5:0] g;      // g[5]=G6 .. g[0]=G1
        logic [1:0] seq;
        logic       se;
        logic       fe;
        logic       lv;
        logic       sl;
        logic       lb;
        logic [2:0] rsv;
    } status_t;

    function automatic logic [15:0] crc_octet(input logic [15:0] crc_in,
                                              input logic [7:0]  octet);
        logic [15:0] c;
        c = crc_in ^ {8'h00, octet};
        for (int b = 0; b < 8; b++) begin
            if (c[0]) c = (c >> 1) ^ CRC_POLY_REV;
            else      c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/pr_event_accum.sv
module pr_event_accum
    import perf_report_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_i,
    input  logic    loopback_i,
    input  logic    crc_ev_i,
    input  logic    sef_ev_i,
    input  logic    fbe_ev_i,
    input  logic    lcv_ev_i,
    input  logic    slip_ev_i,
    output status_t status_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] crc_cnt;
        logic             se;
        logic             fe;
        logic             lv;
        logic             sl;
        logic [1:0]       seq;
    } acc_t;

    acc_t state_d, state_q;
    logic [31:0] cnt_ext;

    // Bin the running tally and assemble this second's status word.
    always_comb begin
        cnt_ext         = 32'(state_q.crc_cnt);
        status_o        = '0;
        status_o.seq    = state_q.seq;
        status_o.se     = state_q.se;
        status_o.fe     = state_q.fe;
        status_o.lv     = state_q.lv;
        status_o.sl     = state_q.sl;
        status_o.lb     = loopback_i;
        status_o.rsv    = 3'b000;
        if (cnt_ext >= 32'd320)      status_o.g[5] = 1'b1;
        else if (cnt_ext >= 32'd101) status_o.g[4] = 1'b1;
        else if (cnt_ext >= 32'd11)  status_o.g[3] = 1'b1;
        else if (cnt_ext >= 32'd6)   status_o.g[2] = 1'b1;
        else if (cnt_ext >= 32'd2)   status_o.g[1] = 1'b1;
        else if (cnt_ext == 32'd1)   status_o.g[0] = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d.crc_cnt = {{(CNT_W-1){1'b0}}, crc_ev_i};
            state_d.se      = sef_ev_i;
            state_d.fe      = fbe_ev_i;
            state_d.lv      = lcv_ev_i;
            state_d.sl      = slip_ev_i;
            state_d.seq     = state_q.seq + 2'd1;
        end else begin
            if (crc_ev_i && (state_q.crc_cnt != CNT_MAX))
                state_d.crc_cnt = state_q.crc_cnt + 1'b1;
            state_d.se = state_q.se | sef_ev_i;
            state_d.fe = state_q.fe | fbe_ev_i;
            state_d.lv = state_q.lv | lcv_ev_i;
            state_d.sl = state_q.sl | slip_ev_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    p_bins_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |-> $onehot0(status_o.g));

    p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> state_q.seq == $past(state_q.seq) + 2'd1);

    p_restart_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> state_q.crc_cnt == {{(CNT_W-1){1'b0}}, $past(crc_ev_i)});

    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.crc_cnt == CNT_MAX && !tick_i) |=> state_q.crc_cnt == CNT_MAX);

endmodule

// File: rtl/pr_history.sv
module pr_history
    import perf_report_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  status_t             status_i,
    output status_t [DEPTH-1:0] hist_o
);

    typedef struct packed {
        status_t [DEPTH-1:0] slot;
    } hist_t;

    hist_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d.slot[0] = status_i;
            for (int k = 1; k < DEPTH; k++)
                state_d.slot[k] = state_q.slot[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign hist_o = state_q.slot;

    p_newest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> state_q.slot[0] == $past(status_i));

    for (genvar k = 1; k < DEPTH; k++) begin : g_age
        p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tick_i |=> state_q.slot[k] == $past(state_q.slot[k-1]));
        p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_i |=> $stable(state_q.slot[k]));
    end

endmodule

// File: rtl/pr_frame_tx.sv
module pr_frame_tx
    import perf_report_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                carrier_i,
    input  status_t [DEPTH-1:0] hist_i,
    input  logic                ready_i,
    output logic                valid_o,
    output logic [7:0]          data_o,
    output logic                sop_o,
    output logic                eop_o
);

    localparam int BODY_N    = 2 * DEPTH;
    localparam int FRAME_LEN = HDR_OCTETS + BODY_N + FCS_OCTETS;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int BODY_W    = $clog2(BODY_N);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_FCSL = IDX_W'(FRAME_LEN - 2);
    localparam logic [IDX_W-1:0] IDX_BODY = IDX_W'(HDR_OCTETS);

    typedef struct packed {
        logic                busy;
        logic                pend;
        logic [IDX_W-1:0]    idx;
        logic [7:0]          addr;
        logic [15:0]         crc;
        status_t [DEPTH-1:0] snap;
    } tx_t;

    tx_t         state_d, state_q;
    logic [7:0]  body [BODY_N];
    logic [7:0]  cur;
    logic [BODY_W-1:0] body_idx;
    logic        fire;
    logic        last;

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            body[2*k]     = state_q.snap[k][15:8];
            body[2*k + 1] = state_q.snap[k][7:0];
        end
        body_idx = BODY_W'(state_q.idx - IDX_BODY);
        if (state_q.idx == '0)                 cur = state_q.addr;
        else if (state_q.idx == IDX_W'(1))     cur = ADDR_TEI;
        else if (state_q.idx == IDX_W'(2))     cur = CTRL_UI;
        else if (state_q.idx == IDX_FCSL)      cur = ~state_q.crc[7:0];
        else if (state_q.idx == IDX_LAST)      cur = ~state_q.crc[15:8];
        else                                   cur = body[body_idx];
    end

    assign fire = state_q.busy && ready_i;
    assign last = state_q.idx == IDX_LAST;

    always_comb begin
        state_d = state_q;
        if (start_i) state_d.pend = 1'b1;
        if (fire) begin
            if (state_q.idx < IDX_FCSL)
                state_d.crc = crc_octet(state_q.crc, cur);
            if (last) begin
                state_d.busy = 1'b0;
                state_d.idx  = '0;
            end else begin
                state_d.idx  = state_q.idx + 1'b1;
            end
        end
        if (!state_q.busy && state_q.pend) begin
            state_d.busy = 1'b1;
            state_d.pend = start_i;
            state_d.idx  = '0;
            state_d.crc  = CRC_PRESET;
            state_d.snap = hist_i;
            state_d.addr = carrier_i ? ADDR_CARRIER : ADDR_CUSTOMER;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign valid_o = state_q.busy;
    assign data_o  = cur;
    assign sop_o   = state_q.busy && (state_q.idx == '0);
    assign eop_o   = state_q.busy && last;

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=>
            (valid_o && $stable(data_o) && $stable(sop_o) && $stable(eop_o)));

    p_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !eop_o) |=> (valid_o && !sop_o));

    p_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q.busy) |=> state_q.pend);

    p_markers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sop_o && eop_o));

endmodule

// File: rtl/perf_report_gen.sv
module perf_report_gen
    import perf_report_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int HIST_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick_i,
    input  logic       carrier_i,
    input  logic       loopback_i,
    input  logic       crc_err_i,
    input  logic       sev_frm_i,
    input  logic       fbit_err_i,
    input  logic       lcv_i,
    input  logic       slip_i,
    input  logic       rep_ready_i,
    output logic       rep_valid_o,
    output logic [7:0] rep_data_o,
    output logic       rep_sop_o,
    output logic       rep_eop_o
);

    status_t                  sec_status;
    status_t [HIST_DEPTH-1:0] hist;

    pr_event_accum #(.CNT_W(CNT_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (sec_tick_i),
        .loopback_i (loopback_i),
        .crc_ev_i   (crc_err_i),
        .sef_ev_i   (sev_frm_i),
        .fbe_ev_i   (fbit_err_i),
        .lcv_ev_i   (lcv_i),
        .slip_ev_i  (slip_i),
        .status_o   (sec_status)
    );

    pr_history #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (sec_tick_i),
        .status_i (sec_status),
        .hist_o   (hist)
    );

    pr_frame_tx #(.DEPTH(HIST_DEPTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (sec_tick_i),
        .carrier_i (carrier_i),
        .hist_i    (hist),
        .ready_i   (rep_ready_i),
        .valid_o   (rep_valid_o),
        .data_o    (rep_data_o),
        .sop_o     (rep_sop_o),
        .eop_o     (rep_eop_o)
    );

    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_i |-> (sec_status.rsv == 3'b000 && sec_status.lb == loopback_i));

endmodule

// File: tb/test_perf_report_gen.sv
module test_perf_report_gen;

    localparam int FLEN = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, car = 0, lb = 0, crc = 0, sef = 0, fbe = 0, lcv = 0, slp = 0;
    logic ready = 0;
    logic valid, sop, eop;
    logic [7:0] data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    logic [15:0] hist_m [4];
    int          seq_m = 0;
    bit          carry_ev = 0;
    logic [7:0]  exp_f [FLEN];
    logic [7:0]  got_f [FLEN];

    always #2.5 clk = ~clk;

    perf_report_gen i_perf_report_gen (
        .clk(clk), .rst_n(rst_n), .sec_tick_i(tick), .carrier_i(car),
        .loopback_i(lb), .crc_err_i(crc), .sev_frm_i(sef), .fbit_err_i(fbe),
        .lcv_i(lcv), .slip_i(slp), .rep_ready_i(ready), .rep_valid_o(valid),
        .rep_data_o(data), .rep_sop_o(sop), .rep_eop_o(eop)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, exp_f[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [15:0] mk_status(input int cnt, input bit se, fe, lv, sl,
                                              input bit l, input int seq);
        logic [5:0] g = '0;
        if (cnt > 511) cnt = 511;
        if (cnt >= 320)      g = 6'b100000;
        else if (cnt >= 101) g = 6'b010000;
        else if (cnt >= 11)  g = 6'b001000;
        else if (cnt >= 6)   g = 6'b000100;
        else if (cnt >= 2)   g = 6'b000010;
        else if (cnt == 1)   g = 6'b000001;
        return {g, 2'(seq), se, fe, lv, sl, l, 3'b000};
    endfunction

    function automatic void build_exp(input bit c);
        logic [15:0] f;
        exp_f[0] = c ? 8'h3A : 8'h38;
        exp_f[1] = 8'h01;
        exp_f[2] = 8'h03;
        for (int k = 0; k < 4; k++) begin
            exp_f[3 + 2*k] = hist_m[k][15:8];
            exp_f[4 + 2*k] = hist_m[k][7:0];
        end
        f = crc_ref(11);
        exp_f[11] = f[7:0];
        exp_f[12] = f[15:8];
    endfunction

    function automatic void push_hist(input logic [15:0] s);
        hist_m[3] = hist_m[2];
        hist_m[2] = hist_m[1];
        hist_m[1] = hist_m[0];
        hist_m[0] = s;
        seq_m = (seq_m + 1) % 4;
    endfunction

    // Collect one frame and compare it with exp_f.
    task automatic get_frame(input bit stall);
        int n = 0, guard = 0;
        bit held = 0;
        logic [7:0] held_b = '0;
        while (n < FLEN && guard < 400) begin
            @(negedge clk);
            ready = stall ? (cyc % 3 != 0) : 1'b1;
            #0.5;
            guard++;
            if (held) begin
                chk(valid && data == held_b, "R11 hold", data, held_b);
                held = 0;
            end
            if (valid && ready) begin
                got_f[n] = data;
                chk(sop == (n == 0), "R2 sop", sop, n == 0);
                chk(eop == (n == FLEN-1), "R2 eop", eop, n == FLEN-1);
                if (n == 0)       chk(data == exp_f[n], "R1 address", data, exp_f[n]);
                else if (n < 3)   chk(data == exp_f[n], "R2 header", data, exp_f[n]);
                else if (n < 11)  chk(data == exp_f[n], "R7 status octet", data, exp_f[n]);
                else              chk(data == exp_f[n], "R8 fcs", data, exp_f[n]);
                n++;
            end else if (valid) begin
                held = 1;
                held_b = data;
            end
        end
        @(negedge clk);
        ready = 0;
        chk(n == FLEN, "R2 length", n, FLEN);
        chk(got_f[3][7:2] == exp_f[3][7:2], "R3 range flags", got_f[3][7:2], exp_f[3][7:2]);
        chk(got_f[4][7:4] == exp_f[4][7:4], "R4 event flags", got_f[4][7:4], exp_f[4][7:4]);
        chk(got_f[4][3:0] == exp_f[4][3:0], "R5 lb/reserved", got_f[4][3:0], exp_f[4][3:0]);
        chk(got_f[3][1:0] == exp_f[3][1:0], "R6 sequence", got_f[3][1:0], exp_f[3][1:0]);
    endtask

    // One second of activity, the tick, then the report.
    task automatic do_second(input int cn, input bit se, fe, lv, sl, l, c,
                             input bit ev_tick, input bit stall);
        int cnt = cn + (carry_ev ? 1 : 0);
        bit s_se = se | carry_ev;
        lb = l;
        car = c;
        for (int i = 0; i < ((cn > 0) ? cn : 1); i++) begin
            @(negedge clk);
            crc = (i < cn);
            sef = se && (i == 0);
            fbe = fe && (i == 0);
            lcv = lv && (i == 0);
            slp = sl && (i == 0);
        end
        @(negedge clk);
        {crc, sef, fbe, lcv, slp} = '0;
        tick = 1;
        if (ev_tick) begin   // R9: these count toward the next second
            crc = 1;
            sef = 1;
        end
        @(negedge clk);
        {tick, crc, sef} = '0;
        push_hist(mk_status(cnt, s_se, fe, lv, sl, l, seq_m));
        carry_ev = ev_tick;
        build_exp(c);
        get_frame(stall);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int counts [12] = '{0, 1, 2, 5, 6, 10, 11, 100, 101, 319, 320, 600};
        for (int k = 0; k < 4; k++) hist_m[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(valid == 0, "R2 reset idle", valid, 0);

        // R3/R4/R5/R6/R7/R10 sweep over every range boundary
        for (int i = 0; i < 12; i++)
            do_second(counts[i], i[0], i[1], i[2], i[3] ^ i[0], i[1] ^ i[2],
                      i[2], 1'b0, i[0]);

        // R9: strobes in the tick cycle land in the next second
        do_second(3, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
        do_second(0, 0, 0, 0, 0, 0, 1, 1'b0, 1'b1);
        do_second(1, 1, 1, 1, 1, 1, 0, 1'b0, 1'b0);

        // R12: second tick while a report is being sent
        begin
            logic [7:0] exp_a [FLEN];
            @(negedge clk);
            tick = 1;
            @(negedge clk);
            tick = 0;
            push_hist(mk_status(0, 0, 0, 0, 0, lb, seq_m));
            build_exp(car);
            exp_a = exp_f;
            ready = 1;
            repeat (3) @(negedge clk);
            chk(valid == 1, "R12 first frame running", valid, 1);
            tick = 1;
            @(negedge clk);
            tick = 0;
            ready = 0;
            push_hist(mk_status(0, 0, 0, 0, 0, lb, seq_m));
            build_exp(car);
            begin
                logic [7:0] exp_b [FLEN];
                exp_b = exp_f;
                // finish frame A (three octets already accepted)
                for (int n = 3; n < FLEN; n++) begin
                    @(negedge clk);
                    ready = 1;
                    #0.5;
                    chk(valid && data == exp_a[n], "R12 first frame", data, exp_a[n]);
                end
                @(negedge clk);
                ready = 0;
                exp_f = exp_b;
                get_frame(1'b0);
            end
        end

        repeat (5) @(negedge clk);
        chk(valid == 0, "R12 single extra frame", valid, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule